// File: doc/BRIEF.md
# Configuration Stream Relocation Filter

This block sits in the path of a 32-bit configuration word stream, between the word source and the device configuration port. It lets a partial configuration compiled for one reconfigurable region be loaded into a different region of the same shape. The filter parses the packet headers as the words go by and finds every write of the frame address. It then rewrites the row, column and half-select fields of that address from offsets held in run-time registers. The minor address and all other words are left alone.

Three modes are available: straight pass-through, address translation, and translation plus frame mirroring. Mirroring is needed when the target region lies on the other half of the device. In that case the frame data is collected one whole frame at a time and sent out with its bit order reversed end for end. The middle word of each frame is the only one not reversed.

Both stream sides use valid/ready handshakes with no register stage at the edge. Offsets and mode are written through a small register interface at any time. They take effect only while no stream is in progress and the mirror buffer is empty. The last word of a stream is marked by `in_last`.

Top module: `cfg_reloc_filter`

## Requirements
- R1: With the mode register at 0 (pass), every input word leaves on `out_data` unchanged in the cycle it is offered. While `out_ready` is high, `in_ready` stays high, so no bubble is added.
- R2: In mode 1 or 2, the word after a frame-address write header is rewritten. Bit 22 (half select) is XORed with the flip register. Bits 18:14 (row) get the row offset added modulo 32. Bits 13:6 (major column) get the signed 8-bit column offset added modulo 256. Bits 31:23, the block type in bits 21:19 and the minor address in bits 5:0 are kept.
- R3: A frame-address write header is a type-1 header with bits 31:29 = 1, operation bits 28:27 = 2 (write), register bits 17:13 = 1 and count bits 10:0 = 1. A write to register 1 with any other count is not rewritten, and neither is any other word.
- R4: After a type-1 write with count n > 0, the next n words are treated as payload and never parsed as headers. A type-2 header (bits 31:29 = 2) with count bits 26:0 = n > 0 gives n payload words for the register named by the most recent type-1 write.
- R5: In mode 2, payload words of register 2 (frame data) are grouped into frames of FRAME_WORDS words. Each frame is sent out after its last word has entered. Output word j holds input word FRAME_WORDS-1-j with its 32 bits reversed, except the middle word (index (FRAME_WORDS-1)/2), which is sent unchanged.
- R6: In mode 2, words that are not frame data (headers, frame addresses, other payloads) bypass the mirror. Frame addresses are still rewritten as in R2.
- R7: In mode 1, frame-data payload words pass unchanged and in order.
- R8: `cfg_sel` picks the register written by `cfg_we`: 0 = mode (bits 1:0), 1 = row offset (bits 4:0), 2 = column offset (bits 7:0, signed), 3 = flip (bit 0). Mode value 3 acts as pass. A value written while a stream is open (first word accepted, word with `in_last` not yet accepted) or while the mirror holds words takes effect only after that.
- R9: After reset, `out_valid` is low while no input is offered, and the filter is in pass mode with zero offsets and no flip.
- R10: On the direct path, `in_ready` follows `out_ready`, so a stalled output stalls the input. A mirrored word held against a low `out_ready` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 32 | Input configuration word |
| in_last | input | 1 | Marks the last word of a stream |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Configuration port takes the word |
| out_data | output | 32 | Output configuration word |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write value |

## Verification
The bench builds the filter with FRAME_WORDS = 5, so the middle word is index 2. A two-frame payload of ten words then shows the mirror wrapping from one frame to the next and stalling the input while it drains, all in a few dozen cycles. The frame-data count field keeps its full 27-bit width. Row and column offsets are chosen to wrap past 31 and below 0 so that the modular arithmetic on both fields is exercised.

// File: rtl/crf_pkg.sv
`timescale 1ns/1ps
package crf_pkg;
  localparam int WORD_W   = 32;
  // frame address fields
  localparam int HALF_BIT = 22;
  localparam int BT_LSB   = 19;
  localparam int BT_W     = 3;
  localparam int ROW_LSB  = 14;
  localparam int ROW_W    = 5;
  localparam int MAJ_LSB  = 6;
  localparam int MAJ_W    = 8;
  localparam int MIN_W    = 6;
  // packet header fields
  localparam int PT_LSB   = 29;
  localparam int OP_LSB   = 27;
  localparam int REG_LSB  = 13;
  localparam int REG_W    = 5;
  localparam int C1_W     = 11;
  localparam int C2_W     = 27;
  localparam logic [2:0] PT_ONE = 3'd1;
  localparam logic [2:0] PT_TWO = 3'd2;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [REG_W-1:0] REG_ADDR  = 5'd1;
  localparam logic [REG_W-1:0] REG_FDATA = 5'd2;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_XLATE  = 2'd1,
    MODE_MIRROR = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PAY_OTHER = 2'd0,
    PAY_ADDR  = 2'd1,
    PAY_FDATA = 2'd2
  } pay_e;

  function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = x[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] far_relocate(
    input logic [WORD_W-1:0] a,
    input logic [ROW_W-1:0]  row_off,
    input logic [MAJ_W-1:0]  col_off,
    input logic              flip);
    logic [WORD_W-1:0] r;
    r = a;
    r[HALF_BIT]              = a[HALF_BIT] ^ flip;
    r[ROW_LSB +: ROW_W]      = a[ROW_LSB +: ROW_W] + row_off;
    r[MAJ_LSB +: MAJ_W]      = a[MAJ_LSB +: MAJ_W] + col_off;
    return r;
  endfunction
endpackage

// File: rtl/crf_pkt_tracker.sv
`timescale 1ns/1ps
module crf_pkt_tracker
  import crf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              fire,
  input  logic              last,
  output logic              is_addr,
  output logic              is_fdata
);
  typedef enum logic {ST_HDR, ST_PAY} st_e;
  st_e             st_q;
  logic [C2_W-1:0] cnt_q;
  pay_e            kind_q;
  logic [REG_W-1:0] last_reg_q;
  logic            last_wr_q;

  logic [2:0]       hdr_pt;
  logic [1:0]       hdr_op;
  logic [REG_W-1:0] hdr_reg;
  logic [C1_W-1:0]  hdr_c1;
  logic [C2_W-1:0]  hdr_c2;

  assign hdr_pt  = word[PT_LSB +: 3];
  assign hdr_op  = word[OP_LSB +: 2];
  assign hdr_reg = word[REG_LSB +: REG_W];
  assign hdr_c1  = word[C1_W-1:0];
  assign hdr_c2  = word[C2_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HDR;
      cnt_q      <= '0;
      kind_q     <= PAY_OTHER;
      last_reg_q <= '0;
      last_wr_q  <= 1'b0;
    end else if (fire) begin
      if (last) begin
        st_q  <= ST_HDR;
        cnt_q <= '0;
      end else if (st_q == ST_PAY) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == C2_W'(1)) st_q <= ST_HDR;
      end else if (hdr_pt == PT_ONE) begin
        last_reg_q <= hdr_reg;
        last_wr_q  <= (hdr_op == OP_WR);
        if (hdr_op == OP_WR && hdr_c1 != '0) begin
          st_q  <= ST_PAY;
          cnt_q <= C2_W'(hdr_c1);
          if (hdr_reg == REG_ADDR && hdr_c1 == C1_W'(1)) kind_q <= PAY_ADDR;
          else if (hdr_reg == REG_FDATA)                 kind_q <= PAY_FDATA;
          else                                           kind_q <= PAY_OTHER;
        end
      end else if (hdr_pt == PT_TWO) begin
        if (last_wr_q && hdr_c2 != '0) begin
          st_q   <= ST_PAY;
          cnt_q  <= hdr_c2;
          kind_q <= (last_reg_q == REG_FDATA) ? PAY_FDATA : PAY_OTHER;
        end
      end
    end
  end

  assign is_addr  = (st_q == ST_PAY) && (kind_q == PAY_ADDR);
  assign is_fdata = (st_q == ST_PAY) && (kind_q == PAY_FDATA);

  AST_PAY_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> (cnt_q != '0)); // R4
  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_addr && fire) |=> !is_addr); // R3
endmodule

// File: rtl/crf_frame_mirror.sv
`timescale 1ns/1ps
module crf_frame_mirror
  import crf_pkg::*;
#(
  parameter int FRAME_WORDS = 41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [WORD_W-1:0] push_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [WORD_W-1:0] pop_data,
  output logic              empty
);
  localparam int IW  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam int MID = (FRAME_WORDS - 1) / 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_WORDS - 1);

  logic [WORD_W-1:0] buf_q [FRAME_WORDS];
  logic [IW-1:0]     fill_q;
  logic [IW-1:0]     drain_q;
  logic              draining_q;
  logic [IW-1:0]     src_idx;
  logic              push_fire;
  logic              frame_full;

  assign push_ready = !draining_q;
  assign push_fire  = push_valid && push_ready;
  assign frame_full = push_fire && (fill_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (push_fire) buf_q[fill_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q     <= '0;
      drain_q    <= '0;
      draining_q <= 1'b0;
    end else if (!draining_q) begin
      if (push_fire) begin
        if (frame_full) begin
          fill_q     <= '0;
          drain_q    <= '0;
          draining_q <= 1'b1;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end else if (pop_ready) begin
      if (drain_q == LAST_IDX) draining_q <= 1'b0;
      else                     drain_q    <= drain_q + 1'b1;
    end
  end

  assign src_idx   = LAST_IDX - drain_q;
  assign pop_valid = draining_q;
  assign pop_data  = (drain_q == IW'(MID)) ? buf_q[MID] : bit_rev(buf_q[src_idx]);
  assign empty     = !draining_q && (fill_q == '0);

  AST_FRAME_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop_valid) |-> $past(push_valid && push_ready)); // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data))); // R10
  AST_NO_FILL_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> (pop_valid || $stable(fill_q))); // R5
endmodule

// File: rtl/crf_ctrl_regs.sv
`timescale 1ns/1ps
module crf_ctrl_regs
  import crf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             load_en,
  output logic [1:0]       mode,
  output logic [ROW_W-1:0] row_off,
  output logic [MAJ_W-1:0] col_off,
  output logic             flip
);
  logic [1:0]       sh_mode;
  logic [ROW_W-1:0] sh_row;
  logic [MAJ_W-1:0] sh_col;
  logic             sh_flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mode <= MODE_PASS;
      sh_row  <= '0;
      sh_col  <= '0;
      sh_flip <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    sh_mode <= cfg_wdata[1:0];
        2'd1:    sh_row  <= cfg_wdata[ROW_W-1:0];
        2'd2:    sh_col  <= cfg_wdata[MAJ_W-1:0];
        default: sh_flip <= cfg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_PASS;
      row_off <= '0;
      col_off <= '0;
      flip    <= 1'b0;
    end else if (load_en) begin
      mode    <= sh_mode;
      row_off <= sh_row;
      col_off <= sh_col;
      flip    <= sh_flip;
    end
  end
endmodule

// File: rtl/cfg_reloc_filter.sv
`timescale 1ns/1ps
module cfg_reloc_filter
  import crf_pkg::*;
#(
  parameter int FRAME_WORDS = 41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata
);
  logic [1:0]       mode_act;
  logic [ROW_W-1:0] row_act;
  logic [MAJ_W-1:0] col_act;
  logic             flip_act;

  logic stream_open_q;
  logic cfg_idle;
  logic in_fire;
  logic p_addr, p_fdata;
  logic xlate_on, mirror_on, to_mirror;
  logic mir_push_valid, mir_push_ready;
  logic mir_pop_valid;
  logic [WORD_W-1:0] mir_pop_data;
  logic mir_empty;
  logic [WORD_W-1:0] addr_new;

  assign xlate_on  = (mode_act == MODE_XLATE) || (mode_act == MODE_MIRROR);
  assign mirror_on = (mode_act == MODE_MIRROR);
  assign to_mirror = mirror_on && p_fdata;
  assign cfg_idle  = !stream_open_q && mir_empty;

  crf_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .load_en(cfg_idle),
    .mode(mode_act), .row_off(row_act), .col_off(col_act), .flip(flip_act)
  );

  crf_pkt_tracker u_trk (
    .clk(clk), .rst_n(rst_n),
    .word(in_data), .fire(in_fire), .last(in_last),
    .is_addr(p_addr), .is_fdata(p_fdata)
  );

  assign mir_push_valid = in_valid && to_mirror && !mir_pop_valid;

  crf_frame_mirror #(.FRAME_WORDS(FRAME_WORDS)) u_mir (
    .clk(clk), .rst_n(rst_n),
    .push_valid(mir_push_valid), .push_ready(mir_push_ready), .push_data(in_data),
    .pop_valid(mir_pop_valid), .pop_ready(out_ready), .pop_data(mir_pop_data),
    .empty(mir_empty)
  );

  assign addr_new = far_relocate(in_data, row_act, col_act, flip_act);

  always_comb begin
    if (mir_pop_valid) begin
      in_ready  = 1'b0;
      out_valid = 1'b1;
      out_data  = mir_pop_data;
    end else if (to_mirror) begin
      in_ready  = mir_push_ready;
      out_valid = 1'b0;
      out_data  = in_data;
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = (xlate_on && p_addr) ? addr_new : in_data;
    end
  end

  assign in_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)       stream_open_q <= 1'b0;
    else if (in_fire) stream_open_q <= !in_last;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_PASS && in_valid && !mir_pop_valid)
      |-> (out_valid && out_data == in_data && in_ready == out_ready)); // R1
  AST_ADDR_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && p_addr)
      |-> (out_data[MIN_W-1:0] == in_data[MIN_W-1:0]
           && out_data[BT_LSB +: BT_W] == in_data[BT_LSB +: BT_W]
           && out_data[31:HALF_BIT+1] == in_data[31:HALF_BIT+1])); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stream_open_q |=> $stable({mode_act, row_act, col_act, flip_act})); // R8
  AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !to_mirror) |-> !in_ready); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !mir_pop_valid) |-> !out_valid); // R9
endmodule

// File: tb/cfg_reloc_filter_tb.sv
`timescale 1ns/1ps
module cfg_reloc_filter_tb;
  localparam int FW  = 5;
  localparam int MIDW = (FW - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic out_valid, out_ready;
  logic [31:0] out_data;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;

  always #2.5 clk = ~clk;

  cfg_reloc_filter #(.FRAME_WORDS(FW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
  );

  int checks = 0, failures = 0, stalls = 0;
  int bp = 0;
  logic [31:0] stim_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] fr [FW];

  // bench copy of the filter settings it expects to be active
  int m_row = 0, m_col = 0, m_flip = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr1(input int op, input int rg, input int cnt);
    return (32'd1 << 29) | (32'(op) << 27) | (32'(rg) << 13) | 32'(cnt);
  endfunction
  function automatic logic [31:0] hdr2(input int cnt);
    return (32'd2 << 29) | (32'd2 << 27) | 32'(cnt);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    int h, row, maj;
    logic [31:0] keep;
    h   = int'(a[22]) ^ m_flip;
    row = (int'(a[18:14]) + m_row) % 32;
    maj = (int'(a[13:6]) + m_col + 256) % 256;
    keep = a & ~(32'h1 << 22) & ~(32'h1f << 14) & ~(32'hff << 6);
    return keep | (32'(h) << 22) | (32'(row) << 14) | (32'(maj) << 6);
  endfunction

  function automatic logic [31:0] mirror_out(input int j);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      int flat, src;
      flat = j * 32 + b;
      src  = FW * 32 - 1 - flat;
      r[b] = (j == MIDW) ? fr[j][b] : fr[src / 32][src % 32];
    end
    return r;
  endfunction

  task automatic put(input logic [31:0] w, input logic [31:0] e, input string tag);
    stim_q.push_back(w); exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic put_frame(input logic [31:0] seed);
    for (int k = 0; k < FW; k++) begin
      fr[k] = seed ^ (32'h0101_0101 * 32'(k + 1)) ^ (32'h8000_0000 >> k);
      stim_q.push_back(fr[k]);
    end
    for (int j = 0; j < FW; j++) begin
      exp_q.push_back(mirror_out(j)); tag_q.push_back("R5");
    end
  endtask

  task automatic drive(input bit close);
    while (stim_q.size() > 0) begin
      in_data  = stim_q.pop_front();
      in_last  = close && (stim_q.size() == 0);
      in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() > 0 && n < 400) begin @(posedge clk); n++; end
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int sel, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // backpressure source
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (bp == 0)      out_ready = 1'b1;
      else if (bp == 1) out_ready = ($urandom_range(0, 3) != 0);
      else              out_ready = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && in_valid && !in_ready) stalls++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", out_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data === e, t, out_data, e);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] a1, a2, a3;
    void'($urandom(7));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", 32'(in_ready), 32'd1);
    @(posedge clk); #1;

    // R1 / R9: pass mode after reset, no bubbles
    a1 = 32'h0042_C0C3;
    stalls = 0;
    put(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R1");
    put(a1, a1, "R9");
    put(hdr1(2, 2, 3), hdr1(2, 2, 3), "R1");
    for (int k = 0; k < 3; k++) put(32'hA5A5_0000 + 32'(k), 32'hA5A5_0000 + 32'(k), "R1");
    put(32'h2000_0000, 32'h2000_0000, "R1");
    drive(1'b1);
    wait_drain("R1");
    chk(stalls == 0, "R1", 32'(stalls), 32'd0);

    // R2, R3, R4, R7: translate mode with wrapping offsets
    cfg_write(0, 1); cfg_write(1, 3); cfg_write(2, 8'hFE); cfg_write(3, 1);
    repeat (2) @(posedge clk); #1;
    m_row = 3; m_col = -2; m_flip = 1;
    bp = 1;
    a1 = (32'd1 << 19) | (32'd30 << 14) | (32'd1 << 6) | 32'd17;   // row wraps, major wraps
    a2 = (32'h1 << 22) | (32'd2 << 19) | (32'd4 << 14) | (32'd200 << 6) | 32'd63;
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R3");
    put(a1, exp_addr(a1), "R2");
    put(hdr1(2, 3, 2), hdr1(2, 3, 2), "R4");
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R4");                // payload, not header
    put(a2, a2, "R4");
    put(hdr1(2, 1, 2), hdr1(2, 1, 2), "R3");                // count 2: no rewrite
    put(a1, a1, "R3");
    put(a2, a2, "R3");
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R3");
    put(a2, exp_addr(a2), "R2");
    put(hdr1(2, 2, 0), hdr1(2, 2, 0), "R4");
    put(hdr2(4), hdr2(4), "R4");
    for (int k = 0; k < 4; k++) put(32'h0F0F_0001 << k, 32'h0F0F_0001 << k, "R7");
    put(32'h2000_0000, 32'h2000_0000, "R4");
    drive(1'b1);
    wait_drain("R2");

    // R10: stalled output stalls the direct path
    bp = 2;
    @(posedge clk); #1;
    put(32'h2000_0000, 32'h2000_0000, "R10");
    in_data = stim_q.pop_front(); in_valid = 1'b1; in_last = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10", 32'(in_ready), 32'd0);
    chk(out_valid == 1'b1 && out_data == 32'h2000_0000, "R10", out_data, 32'h2000_0000);
    bp = 0;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    wait_drain("R10");

    // R5, R6: mirror mode, two frames in one payload
    cfg_write(0, 2);
    repeat (2) @(posedge clk); #1;
    bp = 1;
    a3 = (32'd1 << 14) | (32'd9 << 6) | 32'd3;
    put(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R6");
    put(a3, exp_addr(a3), "R6");
    put(hdr1(2, 2, 0), hdr1(2, 2, 0), "R6");
    put(hdr2(2 * FW), hdr2(2 * FW), "R6");
    put_frame(32'h1234_5678);
    put_frame(32'hCAFE_0001);
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R6");
    put(a1, exp_addr(a1), "R6");
    put(32'h2000_0000, 32'h2000_0000, "R6");
    drive(1'b1);
    wait_drain("R5");

    // R8: settings written mid-stream wait for the stream to close
    cfg_write(0, 1);
    repeat (2) @(posedge clk); #1;
    bp = 0;
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R8");
    put(a2, exp_addr(a2), "R8");
    drive(1'b0);
    cfg_write(1, 7); cfg_write(3, 0);
    repeat (3) @(posedge clk); #1;
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R8");
    put(a1, exp_addr(a1), "R8");                           // old settings still apply
    put(32'h2000_0000, 32'h2000_0000, "R8");
    drive(1'b1);
    wait_drain("R8");
    m_row = 7; m_flip = 0;
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R8");
    put(a1, exp_addr(a1), "R8");                           // new settings
    put(32'h2000_0000, 32'h2000_0000, "R8");
    drive(1'b1);
    wait_drain("R8");

    // R8: mode value 3 behaves as pass
    cfg_write(0, 3);
    repeat (2) @(posedge clk); #1;
    bp = 1;
    put(hdr1(2, 1, 1), hdr1(2, 1, 1), "R8");
    put(a1, a1, "R8");
    put(hdr1(2, 2, FW), hdr1(2, 2, FW), "R8");
    for (int k = 0; k < FW; k++) put(32'h0000_0001 << k, 32'h0000_0001 << k, "R8");
    put(32'h2000_0000, 32'h2000_0000, "R8");
    drive(1'b1);
    wait_drain("R8");

    finish_run();
  end
endmodule